// File: doc/BRIEF.md
# SPI Register Slave with Frame Validation

This block is a mode-0 SPI target that gives an external controller read and write access to a small internal register file. Every transaction is a fixed 32-bit frame sent MSB first. As the controller shifts in its command, the block shifts back a status byte, supplied by a neighbouring interrupt-status block, followed by the contents that the addressed register held before this frame. The old contents are looked up as soon as the address field is complete, so a write returns the value it is about to replace in the same frame.

A write lands only when chip select rises and the frame passed all three checks: exactly 32 clock edges, odd overall parity, and an address that names a writable register. A wrong bit count or a parity failure raises a one-cycle event toward the interrupt-status block, and the frame is discarded. A fixed-pattern test register can be read, and it also returns its pattern during a write, but it never changes. Any other unmapped address reads as zero. SCLK, chip select and MOSI are oversampled in the system clock domain through synchronizers. Edges are found there, and the MISO driver is enabled only while chip select is low.

Top module: `spi_frame_regs`

## Requirements
- R1: After reset, all writable registers read as zero, the MISO enable is low, and neither error event is asserted.
- R2: The MISO enable is high while chip select is low and low while chip select is high.
- R3: The first 8 MISO bits of a frame carry `irq_flags` as sampled when chip select fell, MSB first. MISO changes after SCLK falling edges, and the controller samples it on SCLK rising edges.
- R4: MISO bits 9 to 32 carry the 24-bit contents the addressed register held before the frame, so a write returns the previous value.
- R5: The incoming frame is, MSB first: bit 31 = access type (1 write, 0 read), bits 30:25 = address, bits 24:1 = data, bit 0 = parity. A valid write to a writable address (0x01, 0x02 or 0x03, exposed on `cfg_regs` at bit offset 24*(address-1)) updates that register after chip select rises.
- R6: A frame with at least one SCLK rising edge and a count other than 32 raises `frame_err` for one cycle and commits nothing.
- R7: A 32-bit frame whose count of ones, parity bit included, is even raises `parity_err` for one cycle and commits nothing. A frame that also has the wrong length reports only `frame_err`.
- R8: An address that maps to nothing returns zero in the data field, and a write to it changes no register.
- R9: Address 0x3C is a read-only test register that returns 0x5AA5C3 on both reads and writes, and a write to it has no effect.
- R10: A chip select pulse with no SCLK edges raises no error and changes no register.
- R11: A read frame (bit 31 = 0) never changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| irq_flags | input | 8 | Status byte from the interrupt-status block |
| frame_err | output | 1 | One-cycle event: wrong frame bit count |
| parity_err | output | 1 | One-cycle event: even parity on a full frame |
| cfg_regs | output | 72 | Packed contents of the three writable registers |

## Verification
The hardest case to reach is a write frame whose MISO data field has to show the value that this same frame then replaces. To check it, the stimulus first writes a register, then writes it again. The expected old value comes from the bench's model as it stood before the frame was queued. The bench also drives truncated frames, overlong frames, frames with flipped parity and chip select pulses with no SCLK edges. For each it checks the error events and the packed register outputs before the next frame starts.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

   typedef enum logic [1:0] {
      VERD_IDLE,
      VERD_OK,
      VERD_LEN,
      VERD_PAR
   } verdict_e;

   // Length errors take precedence over parity errors.
   function automatic verdict_e judge_frame(input logic any_bits,
                                            input logic len_ok,
                                            input logic par_ok);
      verdict_e v;
      if (!any_bits)    v = VERD_IDLE;
      else if (!len_ok) v = VERD_LEN;
      else if (!par_ok) v = VERD_PAR;
      else              v = VERD_OK;
      return v;
   endfunction

endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_frame_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= d_async;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_regfile.sv
module spi_frame_regfile #(
   parameter int                ADDR_W       = 6,
   parameter int                DATA_W       = 24,
   parameter int                NUM_RW       = 3,
   parameter int                RW_BASE      = 1,
   parameter bit                HAS_TEST     = 1'b1,
   parameter logic [ADDR_W-1:0] TEST_ADDR    = 6'h3C,
   parameter logic [DATA_W-1:0] TEST_PATTERN = 24'h5AA5C3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NUM_RW*DATA_W-1:0] cfg_regs
);
   localparam int RW_LAST = RW_BASE + NUM_RW - 1;

   generate
      if (RW_LAST >= (1 << ADDR_W)) begin : g_bad_map
         $error("writable range exceeds address space");
      end
      if (HAS_TEST && int'(TEST_ADDR) >= RW_BASE && int'(TEST_ADDR) <= RW_LAST) begin : g_bad_test
         $error("test address overlaps writable range");
      end
   endgenerate

   logic [DATA_W-1:0] regs [NUM_RW];
   logic [NUM_RW-1:0] rd_hit;
   logic              test_hit;

   generate
      for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(RW_BASE + i))
               regs[i] <= wr_data;
         end
         assign rd_hit[i] = (rd_addr == ADDR_W'(RW_BASE + i));
         assign cfg_regs[i*DATA_W +: DATA_W] = regs[i];
      end

      if (HAS_TEST) begin : g_test
         assign test_hit = (rd_addr == TEST_ADDR);
      end else begin : g_no_test
         assign test_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_data = test_hit ? TEST_PATTERN : '0;
      for (int i = 0; i < NUM_RW; i++)
         if (rd_hit[i]) rd_data = regs[i];
   end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_frame_pkg::*;
#(
   parameter int FRAME_W = 32,
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 24,
   parameter int STAT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic [STAT_W-1:0] irq_flags,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso,
   output logic              miso_oe,
   output logic              frame_err,
   output logic              parity_err
);
   localparam int CNT_W    = $clog2(FRAME_W + 1) + 1;
   localparam int ADDR_END = 1 + ADDR_W;
   localparam int OLD_W    = FRAME_W - STAT_W;

   generate
      if (FRAME_W != ADDR_W + DATA_W + 2) begin : g_bad_frame
         $error("frame width must be type + address + data + parity");
      end
      if (OLD_W != DATA_W) begin : g_bad_out
         $error("status byte plus data must fill the frame");
      end
   endgenerate

   logic               sclk_q, cs_q;
   logic [FRAME_W-1:0] rx_sr, tx_word, tx_view;
   logic [CNT_W-1:0]   rx_cnt, tx_idx;
   logic               in_frame, cs_fall, cs_rise, sclk_rise, sclk_fall;
   verdict_e           verdict;

   assign in_frame  = ~cs_n_s & ~cs_q;
   assign cs_fall   = ~cs_n_s &  cs_q;
   assign cs_rise   =  cs_n_s & ~cs_q;
   assign sclk_rise = in_frame &  sclk_s & ~sclk_q;
   assign sclk_fall = in_frame & ~sclk_s &  sclk_q;

   // Address is complete once the bit arriving now is shifted in.
   assign rd_addr = {rx_sr[ADDR_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
         rx_sr   <= '0;
         rx_cnt  <= '0;
         tx_word <= '0;
         tx_idx  <= '0;
      end else begin
         sclk_q <= sclk_s;
         cs_q   <= cs_n_s;
         if (cs_fall) begin
            rx_sr   <= '0;
            rx_cnt  <= '0;
            tx_idx  <= '0;
            tx_word <= {irq_flags, {OLD_W{1'b0}}};
         end else begin
            if (sclk_rise) begin
               rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
               if (rx_cnt != '1) rx_cnt <= rx_cnt + 1'b1;
               if (rx_cnt == CNT_W'(ADDR_END - 1))
                  tx_word[OLD_W-1:0] <= rd_data;
            end
            if (sclk_fall && tx_idx != '1) tx_idx <= tx_idx + 1'b1;
         end
      end
   end

   assign tx_view = tx_word << tx_idx;
   assign miso    = tx_view[FRAME_W-1];
   assign miso_oe = ~cs_q;

   assign verdict = judge_frame(rx_cnt != '0,
                                rx_cnt == CNT_W'(FRAME_W),
                                ^rx_sr);

   assign wr_en   = cs_rise && verdict == VERD_OK && rx_sr[FRAME_W-1];
   assign wr_addr = rx_sr[FRAME_W-2 -: ADDR_W];
   assign wr_data = rx_sr[DATA_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         frame_err  <= cs_rise && verdict == VERD_LEN;
         parity_err <= cs_rise && verdict == VERD_PAR;
      end
   end
endmodule

// File: rtl/spi_frame_regs.sv
module spi_frame_regs #(
   parameter int                ADDR_W       = 6,
   parameter int                DATA_W       = 24,
   parameter int                STAT_W       = 8,
   parameter int                SYNC_STAGES  = 2,
   parameter int                NUM_RW       = 3,
   parameter int                RW_BASE      = 1,
   parameter bit                HAS_TEST     = 1'b1,
   parameter logic [ADDR_W-1:0] TEST_ADDR    = 6'h3C,
   parameter logic [DATA_W-1:0] TEST_PATTERN = 24'h5AA5C3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spi_sclk,
   input  logic                     spi_cs_n,
   input  logic                     spi_mosi,
   output logic                     spi_miso,
   output logic                     spi_miso_oe,
   input  logic [STAT_W-1:0]        irq_flags,
   output logic                     frame_err,
   output logic                     parity_err,
   output logic [NUM_RW*DATA_W-1:0] cfg_regs
);
   localparam int FRAME_W = ADDR_W + DATA_W + 2;

   logic [2:0]        pins_s;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   // Order: {cs_n, sclk, mosi}; cs_n idles high.
   spi_frame_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_async({spi_cs_n, spi_sclk, spi_mosi}),
      .q_sync(pins_s)
   );

   spi_frame_engine #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .STAT_W(STAT_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(pins_s[1]), .cs_n_s(pins_s[2]), .mosi_s(pins_s[0]),
      .irq_flags(irq_flags), .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .miso(spi_miso), .miso_oe(spi_miso_oe),
      .frame_err(frame_err), .parity_err(parity_err)
   );

   spi_frame_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RW(NUM_RW),
                       .RW_BASE(RW_BASE), .HAS_TEST(HAS_TEST),
                       .TEST_ADDR(TEST_ADDR), .TEST_PATTERN(TEST_PATTERN)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cfg_regs(cfg_regs)
   );
endmodule

// File: rtl/spi_frame_regs_chk.sv
module spi_frame_regs_chk #(
   parameter int CFG_W = 72
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spi_miso_oe,
   input logic             frame_err,
   input logic             parity_err,
   input logic [CFG_W-1:0] cfg_regs
);
   // R6 / R7: a frame gets at most one verdict.
   a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_err && parity_err));

   // R6: the length event lasts one cycle.
   a_r6_len_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R7: the parity event lasts one cycle.
   a_r7_par_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> !parity_err);

   // R6 / R10: events only follow the end of a selected frame.
   a_r10_events_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err || parity_err) |-> (!spi_miso_oe && $past(spi_miso_oe)));

   // R5: registers change only right after chip select is released.
   a_r5_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_regs) |-> (!spi_miso_oe && $past(spi_miso_oe)));

   // R2: a frame's enable window closes before anything is committed.
   a_r2_regs_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_miso_oe && $past(spi_miso_oe)) |-> $stable(cfg_regs));
endmodule

bind spi_frame_regs spi_frame_regs_chk #(.CFG_W(NUM_RW*DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_miso_oe(spi_miso_oe),
   .frame_err(frame_err), .parity_err(parity_err), .cfg_regs(cfg_regs)
);

// File: tb/test_spi_frame_regs.sv
module test_spi_frame_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso, spi_miso_oe, frame_err, parity_err;
   logic [7:0]  irq_flags = 8'h5A;
   logic [71:0] cfg_regs;

   always #2.5 clk = ~clk;   // 200 MHz

   spi_frame_regs i_spi_frame_regs (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .irq_flags(irq_flags), .frame_err(frame_err), .parity_err(parity_err),
      .cfg_regs(cfg_regs)
   );

   localparam logic [5:0]  TEST_A = 6'h3C;
   localparam logic [23:0] TEST_P = 24'h5AA5C3;

   int          checks = 0, fails = 0, fe_cnt = 0, pe_cnt = 0;
   bit          done = 1'b0;
   logic [23:0] model [1:3];

   logic [31:0] q_word [$];
   int          q_err  [$];
   logic [71:0] q_cfg  [$];
   string       q_tag  [$];

   always @(posedge clk) begin
      if (frame_err)  fe_cnt++;
      if (parity_err) pe_cnt++;
   end

   function automatic logic [71:0] model_cfg();
      return {model[3], model[2], model[1]};
   endfunction

   function automatic logic [23:0] old_of(input logic [5:0] a);
      if (a >= 6'd1 && a <= 6'd3) return model[a];
      if (a == TEST_A) return TEST_P;
      return 24'h0;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: queues the expectation, then plays the frame on the pins.
   task automatic xfer(input logic wr, input logic [5:0] addr, input logic [23:0] data,
                       input int nbits, input bit bad_par, input string tag);
      logic [30:0] body;
      logic [31:0] frame;
      int          err;
      body  = {wr, addr, data};
      frame = {body, ~(^body) ^ bad_par};
      err   = (nbits != 32) ? 1 : (bad_par ? 2 : 0);
      q_word.push_back({irq_flags, old_of(addr)});
      if (err == 0 && wr && addr >= 6'd1 && addr <= 6'd3) model[addr] = data;
      q_err.push_back(err);
      q_cfg.push_back(model_cfg());
      q_tag.push_back(tag);
      spi_cs_n = 1'b0;
      wait_clk(8);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 32) ? frame[31-i] : 1'b0;
         wait_clk(8);
         spi_sclk = 1'b1;
         wait_clk(8);
         spi_sclk = 1'b0;
      end
      wait_clk(8);
      spi_cs_n = 1'b1;
      wait_clk(24);
   endtask

   // Monitor: collects MISO per frame and compares against the queue.
   initial begin
      forever begin
         int          n, fe0, pe0;
         logic [31:0] w, m;
         bit          oe_bad;
         @(negedge spi_cs_n);
         n = 0; w = '0; oe_bad = 1'b0; fe0 = fe_cnt; pe0 = pe_cnt;
         forever begin
            @(posedge spi_sclk or posedge spi_cs_n);
            if (spi_cs_n) break;
            if (spi_miso_oe !== 1'b1) oe_bad = 1'b1;
            if (n < 32) w[31-n] = spi_miso;
            n++;
         end
         if (n > 0) begin
            logic [31:0] ew;
            int          ee;
            logic [71:0] ec;
            string       tg;
            ew = q_word.pop_front(); ee = q_err.pop_front();
            ec = q_cfg.pop_front();  tg = q_tag.pop_front();
            m  = (n >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> n);
            check({tg, " R2"}, "miso_oe low during frame", 72'(oe_bad), 72'(0));
            check({tg, " R3 R4"}, "miso word", 72'(w & m), 72'(ew & m));
            repeat (12) @(negedge clk);
            check({tg, " R6"}, "frame_err count", 72'(fe_cnt - fe0), 72'(ee == 1));
            check({tg, " R7"}, "parity_err count", 72'(pe_cnt - pe0), 72'(ee == 2));
            check({tg, " R5"}, "cfg_regs", cfg_regs, ec);
            check({tg, " R2"}, "miso_oe after release", 72'(spi_miso_oe), 72'(0));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int fe0, pe0;
      model[1] = '0; model[2] = '0; model[3] = '0;
      wait_clk(5);
      check("R1", "miso_oe in reset", 72'(spi_miso_oe), 72'(0));
      rst_n = 1'b1;
      wait_clk(5);
      check("R1", "cfg_regs after reset", cfg_regs, 72'(0));
      check("R1", "error events after reset", 72'({frame_err, parity_err}), 72'(0));

      xfer(1'b0, 6'd1, 24'h0,      32, 1'b0, "R11 read reg1");
      xfer(1'b1, 6'd1, 24'h123456, 32, 1'b0, "R5 write reg1");
      irq_flags = 8'h81;
      xfer(1'b1, 6'd2, 24'hABCDEF, 32, 1'b0, "R5 write reg2");
      xfer(1'b0, 6'd1, 24'hFFFFFF, 32, 1'b0, "R11 read reg1 back");
      xfer(1'b1, 6'd1, 24'h00FF00, 32, 1'b0, "R4 overwrite reg1 returns old");
      xfer(1'b1, 6'd3, 24'h0F0F0F, 32, 1'b0, "R5 write reg3");
      xfer(1'b1, 6'h20, 24'h777777, 32, 1'b0, "R8 write unmapped");
      xfer(1'b0, 6'h20, 24'h0,     32, 1'b0, "R8 read unmapped");
      xfer(1'b1, TEST_A, 24'h111111, 32, 1'b0, "R9 write test reg");
      xfer(1'b0, TEST_A, 24'h0,      32, 1'b0, "R9 read test reg");
      irq_flags = 8'hC3;
      xfer(1'b1, 6'd2, 24'h222222, 20, 1'b0, "R6 short frame");
      xfer(1'b1, 6'd2, 24'h333333, 33, 1'b0, "R6 long frame");
      xfer(1'b1, 6'd2, 24'h444444, 31, 1'b1, "R6 short with bad parity");
      xfer(1'b1, 6'd2, 24'h555555, 32, 1'b1, "R7 bad parity");

      // R10: select pulse with no clock edges
      fe0 = fe_cnt; pe0 = pe_cnt;
      spi_cs_n = 1'b0;
      wait_clk(20);
      spi_cs_n = 1'b1;
      wait_clk(20);
      check("R10", "events on idle select", 72'(fe_cnt - fe0 + pe_cnt - pe0), 72'(0));
      check("R10", "cfg_regs on idle select", cfg_regs, model_cfg());

      xfer(1'b0, 6'd2, 24'h0, 32, 1'b0, "R11 read reg2 after rejects");
      xfer(1'b0, 6'd3, 24'h0, 32, 1'b0, "R11 read reg3");

      wait_clk(40);
      check("R5", "expectation queue drained", 72'(q_word.size()), 72'(0));
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule